// File: doc/BRIEF.md
# Banked Stack Pointer Register File

This block holds the integer register state of a small 32-bit processor core. It has sixteen register numbers. Numbers 0 to 12 are plain storage. Number 13 is the stack pointer. Number 14 is the link register and number 15 is the program counter. The core reads two operands per cycle and writes one result per cycle. Each port uses a 4-bit register number.

The stack pointer is backed by two physical registers: a main bank and a process bank. Number 13 reaches only one of them at a time. In handler mode it always reaches the main bank. In thread mode a stack-select flag picks the bank. The flag is changed by a control-register write, which works only in thread mode, or by an exception-return update. Both banks are word aligned. The program counter is halfword aligned.

A branch-and-link strobe loads the return address into the link register. Separate side ports let exception logic read and write each bank directly. An output shows the stack pointer that is currently active.

Top module: `bsp_regfile`

## Requirements
- R1: After reset, every register reads as zero, both stack banks are zero, and the stack-select flag `sp_sel` is 0.
- R2: Numbers 0 to 12 store whatever the write port writes. Reads are combinational. A write takes effect at the next rising edge, so a read of the same number in the same cycle returns the old value.
- R3: When `handler_mode` is 1, register number 13 (read or write) reaches the main bank, whatever the flag says.
- R4: When `handler_mode` is 0, register number 13 reaches the process bank if `sp_sel` is 1 and the main bank if `sp_sel` is 0.
- R5: `ctl_wr_en` loads `ctl_spsel` into `sp_sel` at the next edge, but only when `handler_mode` is 0. In handler mode it has no effect.
- R6: `exc_ret_en` loads `exc_ret_spsel` into `sp_sel` at the next edge in either mode. It wins over a control write in the same cycle.
- R7: Every write to a stack bank, through number 13 or through a side port, stores bits [1:0] as zero.
- R8: Register number 15 always reads with bit 0 equal to zero, because a write stores bit 0 as zero.
- R9: `bl_en` loads `bl_ret_addr` into register 14 at the next edge. It wins over a port write to number 14 in the same cycle. Otherwise register 14 is ordinary storage.
- R10: `msp_wr_en` and `psp_wr_en` write the main and process banks directly, and `msp_q` and `psp_q` show both banks. A port write through number 13 to the same bank in the same cycle wins over the side write.
- R11: `sp_active` always equals the bank that number 13 currently selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| handler_mode | input | 1 | 1 means handler mode, 0 means thread mode |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port register number |
| wr_data | input | 32 | Write port data |
| ctl_wr_en | input | 1 | Control-register stack-select write strobe |
| ctl_spsel | input | 1 | New flag value for the control write |
| exc_ret_en | input | 1 | Exception-return stack-select update strobe |
| exc_ret_spsel | input | 1 | New flag value for the exception return |
| bl_en | input | 1 | Branch-and-link capture strobe |
| bl_ret_addr | input | 32 | Return address for the link register |
| msp_wr_en | input | 1 | Side write strobe for the main bank |
| msp_wr_data | input | 32 | Side write data for the main bank |
| psp_wr_en | input | 1 | Side write strobe for the process bank |
| psp_wr_data | input | 32 | Side write data for the process bank |
| msp_q | output | 32 | Main bank contents |
| psp_q | output | 32 | Process bank contents |
| sp_active | output | 32 | Stack pointer selected by number 13 |
| sp_sel | output | 1 | Current stack-select flag |

## Verification
The assertions check the following on every cycle:
- Handler mode always exposes the main bank on `sp_active`.
- Thread mode with the flag set exposes the process bank.
- Both banks stay word aligned.
- Register number 15 reads with bit 0 clear.
- The flag ignores control writes made in handler mode.
- The flag follows an exception return one cycle later.
- A branch-and-link capture is visible on register 14 in the next cycle.

Some behaviours show up only through the bench's scenarios, which track register contents over long random sequences against a behavioural model:
- The old-value result when a read and a write hit the same number.
- The priority between a port write and a side write to the same bank.
- Whether a number-13 write lands in the right bank after mode changes.
- The reset contents.

// File: rtl/bsp_regfile.sv
module bsp_regfile #(
  parameter int DW = 32,
  parameter int SP_ALIGN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          handler_mode,
  input  logic [3:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          ctl_wr_en,
  input  logic          ctl_spsel,
  input  logic          exc_ret_en,
  input  logic          exc_ret_spsel,
  input  logic          bl_en,
  input  logic [DW-1:0] bl_ret_addr,
  input  logic          msp_wr_en,
  input  logic [DW-1:0] msp_wr_data,
  input  logic          psp_wr_en,
  input  logic [DW-1:0] psp_wr_data,
  output logic [DW-1:0] msp_q,
  output logic [DW-1:0] psp_q,
  output logic [DW-1:0] sp_active,
  output logic          sp_sel
);
  localparam int NGP = 13;
  localparam logic [3:0] IDX_SP = 4'd13;
  localparam logic [3:0] IDX_LR = 4'd14;
  localparam logic [3:0] IDX_PC = 4'd15;
  localparam logic [DW-1:0] SP_MASK = {{(DW-SP_ALIGN){1'b1}}, {SP_ALIGN{1'b0}}};
  localparam logic [DW-1:0] PC_MASK = {{(DW-1){1'b1}}, 1'b0};

  logic [DW-1:0] gpr [NGP];
  logic [DW-1:0] lr, pc;
  logic          use_psp, wr_sp;

  assign use_psp   = !handler_mode && sp_sel;
  assign sp_active = use_psp ? psp_q : msp_q;
  assign wr_sp     = wr_en && (wr_idx == IDX_SP);

  function automatic logic [DW-1:0] rd_mux(input logic [3:0] idx);
    case (idx)
      IDX_SP:  rd_mux = sp_active;
      IDX_LR:  rd_mux = lr;
      IDX_PC:  rd_mux = pc & PC_MASK;
      default: rd_mux = gpr[idx];
    endcase
  endfunction

  assign rd_a_data = rd_mux(rd_a_idx);
  assign rd_b_data = rd_mux(rd_b_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NGP; i++) gpr[i] <= '0;
    end else if (wr_en && wr_idx < IDX_SP) begin
      gpr[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lr <= '0;
    else if (bl_en) lr <= bl_ret_addr;
    else if (wr_en && wr_idx == IDX_LR) lr <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else if (wr_en && wr_idx == IDX_PC) pc <= wr_data & PC_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msp_q <= '0;
    else if (wr_sp && !use_psp) msp_q <= wr_data & SP_MASK;
    else if (msp_wr_en) msp_q <= msp_wr_data & SP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psp_q <= '0;
    else if (wr_sp && use_psp) psp_q <= wr_data & SP_MASK;
    else if (psp_wr_en) psp_q <= psp_wr_data & SP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_sel <= 1'b0;
    else if (exc_ret_en) sp_sel <= exc_ret_spsel;
    else if (ctl_wr_en && !handler_mode) sp_sel <= ctl_spsel;
  end
endmodule

module bsp_regfile_chk #(
  parameter int DW = 32,
  parameter int SP_ALIGN = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          handler_mode,
  input logic [3:0]    rd_a_idx,
  input logic [DW-1:0] rd_a_data,
  input logic [3:0]    rd_b_idx,
  input logic [DW-1:0] rd_b_data,
  input logic          ctl_wr_en,
  input logic          exc_ret_en,
  input logic          exc_ret_spsel,
  input logic          bl_en,
  input logic [DW-1:0] bl_ret_addr,
  input logic [DW-1:0] msp_q,
  input logic [DW-1:0] psp_q,
  input logic [DW-1:0] sp_active,
  input logic          sp_sel
);
  assert_handler_main_R3: assert property (@(posedge clk) disable iff (!rst_n)
    handler_mode |-> sp_active == msp_q);
  assert_thread_process_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!handler_mode && sp_sel) |-> sp_active == psp_q);
  assert_bank_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msp_q[SP_ALIGN-1:0] == '0) && (psp_q[SP_ALIGN-1:0] == '0));
  assert_pc_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'd15) |-> !rd_a_data[0]);
  assert_ctl_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_mode && ctl_wr_en && !exc_ret_en) |=> sp_sel == $past(sp_sel));
  assert_exc_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ret_en |=> sp_sel == $past(exc_ret_spsel));
  assert_bl_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bl_en |=> (rd_b_idx != 4'd14 || rd_b_data == $past(bl_ret_addr)));
endmodule

bind bsp_regfile bsp_regfile_chk #(.DW(DW), .SP_ALIGN(SP_ALIGN)) u_chk (
  .clk(clk), .rst_n(rst_n), .handler_mode(handler_mode),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .ctl_wr_en(ctl_wr_en), .exc_ret_en(exc_ret_en), .exc_ret_spsel(exc_ret_spsel),
  .bl_en(bl_en), .bl_ret_addr(bl_ret_addr),
  .msp_q(msp_q), .psp_q(psp_q), .sp_active(sp_active), .sp_sel(sp_sel)
);

// File: tb/sim_bsp_regfile.sv
module sim_bsp_regfile;
  logic clk = 0, rst_n = 0;
  logic handler_mode = 0;
  logic [3:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0, bl_ret_addr = 0;
  logic [31:0] msp_wr_data = 0, psp_wr_data = 0, msp_q, psp_q, sp_active;
  logic wr_en = 0, ctl_wr_en = 0, ctl_spsel = 0, exc_ret_en = 0, exc_ret_spsel = 0;
  logic bl_en = 0, msp_wr_en = 0, psp_wr_en = 0, sp_sel;

  always #4 clk = ~clk;

  bsp_regfile u0 (.*);

  logic [31:0] m_reg [16];
  logic [31:0] m_msp, m_psp;
  logic m_sel;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(logic [3:0] i);
    if (i == 13) return (!handler_mode && m_sel) ? m_psp : m_msp;
    return m_reg[i];
  endfunction

  function automatic string tag_of(logic [3:0] i);
    if (i == 13) return handler_mode ? "R3" : "R4";
    if (i == 14) return "R9";
    if (i == 15) return "R8";
    return "R2";
  endfunction

  task automatic compare();
    chk(tag_of(rd_a_idx), rd_a_data, m_read(rd_a_idx));
    chk(tag_of(rd_b_idx), rd_b_data, m_read(rd_b_idx));
    chk("R10 main bank (R7)", msp_q, m_msp);
    chk("R10 process bank (R7)", psp_q, m_psp);
    chk("R11", sp_active, (!handler_mode && m_sel) ? m_psp : m_msp);
    chk("R5/R6 flag", {31'b0, sp_sel}, {31'b0, m_sel});
  endtask

  task automatic model_step();
    logic use_p;
    logic [31:0] nmsp, npsp;
    logic nsel;
    use_p = !handler_mode && m_sel;
    nmsp = m_msp; npsp = m_psp; nsel = m_sel;
    if (msp_wr_en) nmsp = msp_wr_data & ~32'd3;
    if (psp_wr_en) npsp = psp_wr_data & ~32'd3;
    if (wr_en && wr_idx == 13) begin
      if (use_p) npsp = wr_data & ~32'd3; else nmsp = wr_data & ~32'd3;
    end
    if (ctl_wr_en && !handler_mode) nsel = ctl_spsel;
    if (exc_ret_en) nsel = exc_ret_spsel;
    if (wr_en && wr_idx != 13) m_reg[wr_idx] = (wr_idx == 15) ? (wr_data & ~32'd1) : wr_data;
    if (bl_en) m_reg[14] = bl_ret_addr;
    m_msp = nmsp; m_psp = npsp; m_sel = nsel;
  endtask

  task automatic cycle();
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; ctl_wr_en = 0; exc_ret_en = 0; bl_en = 0; msp_wr_en = 0; psp_wr_en = 0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_reg[i] = 0;
    m_msp = 0; m_psp = 0; m_sel = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); #1 chk("R1 reset reg", rd_a_data, 32'd0);
    end
    chk("R1 reset flag", {31'b0, sp_sel}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    // R2: same-cycle read returns old value
    wr_en = 1; wr_idx = 5; wr_data = 32'hCAFE0001; rd_a_idx = 5; rd_b_idx = 5; cycle();
    idle(); cycle();
    // R4/R5: thread switch to process bank, then write SP unaligned (R7)
    ctl_wr_en = 1; ctl_spsel = 1; cycle(); idle();
    wr_en = 1; wr_idx = 13; wr_data = 32'h1234_5677; rd_a_idx = 13; cycle(); idle(); cycle();
    // R3: handler sees main bank; R5 control write ignored in handler
    handler_mode = 1; ctl_wr_en = 1; ctl_spsel = 0; cycle(); idle(); cycle();
    // R6: exception return beats control write
    exc_ret_en = 1; exc_ret_spsel = 1; ctl_wr_en = 1; ctl_spsel = 0; handler_mode = 0; cycle(); idle(); cycle();
    // R9: branch-and-link beats port write to 14
    bl_en = 1; bl_ret_addr = 32'hABCD_0003; wr_en = 1; wr_idx = 14; wr_data = 32'h5; rd_b_idx = 14; cycle(); idle(); cycle();
    // R8: PC odd write
    wr_en = 1; wr_idx = 15; wr_data = 32'hFFFF_FFFF; rd_a_idx = 15; cycle(); idle(); cycle();
    // R10: port write to process bank beats side write
    wr_en = 1; wr_idx = 13; wr_data = 32'h40; psp_wr_en = 1; psp_wr_data = 32'h80;
    msp_wr_en = 1; msp_wr_data = 32'h0000_0107; cycle(); idle(); cycle();
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 15) == 0) handler_mode = ~handler_mode;
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      wr_en = ($urandom_range(0, 2) != 0); wr_idx = 4'($urandom); wr_data = $urandom;
      ctl_wr_en = ($urandom_range(0, 5) == 0); ctl_spsel = 1'($urandom);
      exc_ret_en = ($urandom_range(0, 7) == 0); exc_ret_spsel = 1'($urandom);
      bl_en = ($urandom_range(0, 5) == 0); bl_ret_addr = $urandom;
      msp_wr_en = ($urandom_range(0, 5) == 0); msp_wr_data = $urandom;
      psp_wr_en = ($urandom_range(0, 5) == 0); psp_wr_data = $urandom;
      cycle();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule